// File: doc/BRIEF.md
# Two-Wire Register Access Slave

This block lets an external processor read and write a bank of internal 32-bit registers over a two-wire serial bus. The bus has one clock line and one open-drain data line. A configuration EEPROM shares the same two wires, so the block answers only to its own 7-bit device address and stays silent for every other address. Both bus lines are oversampled by the system clock through synchronizers. The block finds bus conditions and clock edges from the sampled lines, and it pulls the data line low through a single output-enable.

A transaction opens with a START and a device-address byte whose lowest bit selects the direction. A write carries two register-address bytes and then data bytes. A read is a write of the address only, followed by a repeated START and the device address with the read bit set. Register words travel least significant byte first. The register address and the bits inside every byte travel most significant first. A register word is updated only in 16-bit halves, and only once the closing byte of a half has been acknowledged.

Top module: `tws_slave`

## Requirements
- R1: Only the device address 7'b1010100 (0x54) is acknowledged. After any other address, for example the EEPROM's 0x50, the data line is never pulled low until the next START or STOP.
- R2: A START (data falling while clock high) or a STOP (data rising while clock high) aborts any byte in progress and releases the data line. A START always begins a new device-address byte.
- R3: Bit 0 of the device-address byte is the direction (0 = write, 1 = read). After a write address come two register-address bytes, high byte first. The register selected is the address modulo NUM_REGS (8 by default), so higher address bits alias.
- R4: Data byte k of a word carries register bits 8k+7..8k (byte 0 first). Inside every byte, bits are sent most significant first.
- R5: The slave acknowledges a matching device-address byte, both register-address bytes and every write data byte by pulling the data line low during the ninth clock.
- R6: Bits 15:0 of the register are written when byte 1 is acknowledged, and bits 31:16 when byte 3 is acknowledged. A write that ends after byte 0 or byte 2 leaves the unfinished half unchanged. Byte positions repeat modulo 4.
- R7: A repeated START followed by a read address returns the register selected by the last register address, starting at byte 0. Read byte positions repeat modulo 4.
- R8: During a read, a master acknowledge continues with the next byte. A master no-acknowledge makes the slave release the data line and ignore the clock until the next START or STOP.
- R9: While reset is held, and after it is released, the data line is not driven and every register reads zero.
- R10: The slave changes what it drives only while the bus clock is low, so a bit stays stable for the whole clock-high time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, much faster than the bus clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | Bus clock line as seen at the pad |
| sda_i | input | 1 | Bus data line as seen at the pad |
| sda_oe_o | output | 1 | 1 pulls the data line low, 0 releases it |

## Verification
Nearly every internal fault reaches the single output-enable within one byte frame. A wrong byte counter or a wrong phase shows up as a missing or misplaced acknowledge on the ninth clock. A mis-selected read byte shows up as wrong bits during the next read byte. Faults in commit timing or in address assembly stay hidden in the register array until a later read returns the word. For that reason, every write in the bench is followed by a read, and each partial write is paired with a check on the untouched half. The behavioural model also watches the data line on every clock during windows where the slave must stay silent, so a stray drive after a foreign address or after a no-acknowledge is caught in the cycle it occurs.

// File: rtl/tws_pkg.sv
package tws_pkg;
  typedef enum logic [2:0] {
    PH_IDLE = 3'd0,
    PH_DEV  = 3'd1,
    PH_AHI  = 3'd2,
    PH_ALO  = 3'd3,
    PH_WR   = 3'd4,
    PH_RD   = 3'd5,
    PH_IGN  = 3'd6
  } phase_e;

  localparam int BYTE_W   = 8;
  localparam int WORD_W   = 32;
  localparam int WORD_BYT = WORD_W / BYTE_W;
  localparam int RADDR_W  = 16;
  localparam logic [3:0] BIT_ACK  = 4'd8;
  localparam logic [3:0] BIT_DONE = 4'd9;
endpackage

// File: rtl/tws_rst_sync.sv
module tws_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sn
);
  logic [STAGES-1:0] chain_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= {chain_q[STAGES-2:0], 1'b1};
  end

  assign rst_sn = chain_q[STAGES-1];
endmodule

// File: rtl/tws_in_sync.sv
module tws_in_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_sn,
  input  logic scl_i,
  input  logic sda_i,
  output logic scl_s,
  output logic sda_s,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_evt,
  output logic stop_evt
);
  localparam int LINES = 2;

  logic [LINES-1:0] raw;
  logic [STAGES:0]  chain_q [LINES];
  logic [LINES-1:0] cur, prev;

  assign raw = {scl_i, sda_i};

  for (genvar g = 0; g < LINES; g++) begin : g_line
    always_ff @(posedge clk or negedge rst_sn) begin
      if (!rst_sn) chain_q[g] <= '1;
      else         chain_q[g] <= {chain_q[g][STAGES-1:0], raw[g]};
    end
    assign cur[g]  = chain_q[g][STAGES-1];
    assign prev[g] = chain_q[g][STAGES];
  end

  assign scl_s     = cur[1];
  assign sda_s     = cur[0];
  assign scl_rise  = cur[1] & ~prev[1];
  assign scl_fall  = ~cur[1] & prev[1];
  assign start_evt = cur[1] & prev[1] & ~cur[0] & prev[0];
  assign stop_evt  = cur[1] & prev[1] & cur[0] & ~prev[0];
endmodule

// File: rtl/tws_regfile.sv
module tws_regfile #(
  parameter int NUM_REGS = 8,
  parameter int DATA_W   = 32,
  localparam int IDX_W   = (NUM_REGS > 1) ? $clog2(NUM_REGS) : 1,
  localparam int HALF_W  = DATA_W / 2
) (
  input  logic              clk,
  input  logic              rst_sn,
  input  logic              we_lo,
  input  logic              we_hi,
  input  logic [IDX_W-1:0]  wr_idx,
  input  logic [DATA_W-1:0] wdata,
  input  logic [IDX_W-1:0]  rd_idx,
  output logic [DATA_W-1:0] rdata
);
  logic [DATA_W-1:0] mem_q [NUM_REGS];

  for (genvar e = 0; e < NUM_REGS; e++) begin : g_ent
    logic sel, lo_en, hi_en;
    assign sel   = (wr_idx == IDX_W'(e));
    assign lo_en = we_lo & sel;
    assign hi_en = we_hi & sel;

    always_ff @(posedge clk or negedge rst_sn) begin
      if (!rst_sn) begin
        mem_q[e] <= '0;
      end else begin
        if (lo_en) mem_q[e][HALF_W-1:0]      <= wdata[HALF_W-1:0];
        if (hi_en) mem_q[e][DATA_W-1:HALF_W] <= wdata[DATA_W-1:HALF_W];
      end
    end
  end

  assign rdata = mem_q[rd_idx];
endmodule

// File: rtl/tws_slave.sv
module tws_slave
  import tws_pkg::*;
#(
  parameter logic [6:0] DEV_ADDR    = 7'b1010100,
  parameter int         NUM_REGS    = 8,
  parameter int         SYNC_STAGES = 2,
  localparam int        IDX_W       = (NUM_REGS > 1) ? $clog2(NUM_REGS) : 1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_i,
  input  logic sda_i,
  output logic sda_oe_o
);
  logic rst_sn;
  logic scl_s, sda_s, scl_rise, scl_fall, start_evt, stop_evt;

  tws_rst_sync #(.STAGES(SYNC_STAGES)) u_rst (
    .clk(clk), .rst_n(rst_n), .rst_sn(rst_sn)
  );

  tws_in_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_sn(rst_sn), .scl_i(scl_i), .sda_i(sda_i),
    .scl_s(scl_s), .sda_s(sda_s), .scl_rise(scl_rise), .scl_fall(scl_fall),
    .start_evt(start_evt), .stop_evt(stop_evt)
  );

  phase_e                         phase_q, phase_n;
  logic [3:0]                     bit_q, bit_n;
  logic [BYTE_W-1:0]              shreg_q, shreg_n;
  logic [RADDR_W-1:0]             addr_q, addr_n;
  logic [1:0]                     bidx_q, bidx_n;
  logic                           rw_q, rw_n;
  logic                           mack_q, mack_n;
  logic                           oe_q, oe_n;
  logic [WORD_BYT-1:0][BYTE_W-1:0] wbuf_q, wbuf_n;
  logic                           we_lo, we_hi;
  logic [WORD_W-1:0]              rdata;
  logic [BYTE_W-1:0]              rd_cur, rd_nxt;

  tws_regfile #(.NUM_REGS(NUM_REGS), .DATA_W(WORD_W)) u_regs (
    .clk(clk), .rst_sn(rst_sn), .we_lo(we_lo), .we_hi(we_hi),
    .wr_idx(addr_q[IDX_W-1:0]), .wdata(wbuf_q),
    .rd_idx(addr_q[IDX_W-1:0]), .rdata(rdata)
  );

  function automatic logic [BYTE_W-1:0] pick(input logic [WORD_W-1:0] w,
                                             input logic [1:0] k);
    return w[BYTE_W*k +: BYTE_W];
  endfunction

  assign rd_cur = pick(rdata, 2'd0);
  assign rd_nxt = pick(rdata, bidx_q + 2'd1);

  always_comb begin
    phase_n = phase_q;
    bit_n   = bit_q;
    shreg_n = shreg_q;
    addr_n  = addr_q;
    bidx_n  = bidx_q;
    rw_n    = rw_q;
    mack_n  = mack_q;
    oe_n    = oe_q;
    wbuf_n  = wbuf_q;
    we_lo   = 1'b0;
    we_hi   = 1'b0;

    if (start_evt) begin
      phase_n = PH_DEV;
      bit_n   = '0;
      oe_n    = 1'b0;
    end else if (stop_evt) begin
      phase_n = PH_IDLE;
      bit_n   = '0;
      oe_n    = 1'b0;
    end else begin
      unique case (phase_q)
        PH_DEV, PH_AHI, PH_ALO, PH_WR: begin
          if (scl_rise) begin
            if (bit_q < BIT_ACK) shreg_n = {shreg_q[BYTE_W-2:0], sda_s};
            bit_n = bit_q + 4'd1;
          end else if (scl_fall && bit_q == BIT_ACK) begin
            oe_n = 1'b1;
            unique case (phase_q)
              PH_DEV: begin
                if (shreg_q[7:1] == DEV_ADDR) rw_n = shreg_q[0];
                else begin
                  oe_n    = 1'b0;
                  phase_n = PH_IGN;
                end
              end
              PH_AHI:  addr_n[15:8]     = shreg_q;
              PH_ALO:  addr_n[7:0]      = shreg_q;
              default: wbuf_n[bidx_q]   = shreg_q;
            endcase
          end else if (scl_fall && bit_q == BIT_DONE) begin
            oe_n  = 1'b0;
            bit_n = '0;
            unique case (phase_q)
              PH_DEV: begin
                if (rw_q) begin
                  phase_n = PH_RD;
                  bidx_n  = 2'd0;
                  shreg_n = rd_cur;
                  oe_n    = ~rd_cur[BYTE_W-1];
                end else begin
                  phase_n = PH_AHI;
                end
              end
              PH_AHI: phase_n = PH_ALO;
              PH_ALO: begin
                phase_n = PH_WR;
                bidx_n  = 2'd0;
              end
              default: begin
                we_lo  = (bidx_q == 2'd1);
                we_hi  = (bidx_q == 2'd3);
                bidx_n = bidx_q + 2'd1;
              end
            endcase
          end
        end
        PH_RD: begin
          if (scl_rise) begin
            if (bit_q == BIT_ACK) mack_n = ~sda_s;
            bit_n = bit_q + 4'd1;
          end else if (scl_fall) begin
            if (bit_q == BIT_ACK) begin
              oe_n = 1'b0;
            end else if (bit_q == BIT_DONE) begin
              bit_n = '0;
              if (mack_q) begin
                bidx_n  = bidx_q + 2'd1;
                shreg_n = rd_nxt;
                oe_n    = ~rd_nxt[BYTE_W-1];
              end else begin
                phase_n = PH_IGN;
                oe_n    = 1'b0;
              end
            end else if (bit_q != 4'd0) begin
              shreg_n = {shreg_q[BYTE_W-2:0], 1'b0};
              oe_n    = ~shreg_q[BYTE_W-2];
            end
          end
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_sn) begin
    if (!rst_sn) begin
      phase_q <= PH_IDLE;
      bit_q   <= '0;
      shreg_q <= '0;
      addr_q  <= '0;
      bidx_q  <= '0;
      rw_q    <= 1'b0;
      mack_q  <= 1'b0;
      oe_q    <= 1'b0;
      wbuf_q  <= '0;
    end else begin
      phase_q <= phase_n;
      bit_q   <= bit_n;
      shreg_q <= shreg_n;
      addr_q  <= addr_n;
      bidx_q  <= bidx_n;
      rw_q    <= rw_n;
      mack_q  <= mack_n;
      oe_q    <= oe_n;
      wbuf_q  <= wbuf_n;
    end
  end

  assign sda_oe_o = oe_q;
endmodule

// File: rtl/tws_slave_chk.sv
module tws_slave_chk (
  input logic clk,
  input logic rst_n,
  input logic rst_sn,
  input logic scl_s,
  input logic scl_fall,
  input logic start_evt,
  input logic stop_evt,
  input logic we_lo,
  input logic we_hi,
  input logic sda_oe
);
  always @(posedge clk) begin
    if (!rst_n) begin
      AST_RESET_QUIET: assert (!sda_oe); // R9
    end
  end

  AST_DRIVE_ON_LOW_CLK: assert property (@(posedge clk) disable iff (!rst_sn)
    $rose(sda_oe) |-> !scl_s); // R10

  AST_STOP_RELEASES: assert property (@(posedge clk) disable iff (!rst_sn)
    stop_evt |=> !sda_oe); // R2

  AST_START_RELEASES: assert property (@(posedge clk) disable iff (!rst_sn)
    start_evt |=> !sda_oe); // R2

  AST_COMMIT_ON_FALL: assert property (@(posedge clk) disable iff (!rst_sn)
    (we_lo || we_hi) |-> scl_fall); // R6
endmodule

bind tws_slave tws_slave_chk u_chk (
  .clk(clk), .rst_n(rst_n), .rst_sn(rst_sn), .scl_s(scl_s),
  .scl_fall(scl_fall), .start_evt(start_evt), .stop_evt(stop_evt),
  .we_lo(we_lo), .we_hi(we_hi), .sda_oe(sda_oe_o)
);

// File: tb/tb_tws_slave.sv
module tb_tws_slave;
  localparam int CLK_PERIOD = 10;
  localparam int H          = 8;
  localparam int NREG       = 8;
  localparam int WATCHDOG   = 150000;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic m_scl = 1'b1;
  logic m_sda = 1'b1;
  logic sda_oe;
  logic sda_bus;
  logic quiet = 1'b1;
  int   checks = 0;
  int   fails = 0;
  logic [31:0] mdl [NREG];

  assign sda_bus = m_sda & ~sda_oe;

  tws_slave dut (
    .clk(clk), .rst_n(rst_n), .scl_i(m_scl), .sda_i(sda_bus), .sda_oe_o(sda_oe)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // per-clock comparison against the model's silence windows (R1, R8, R9)
  always @(negedge clk) begin
    if (quiet && sda_oe) begin
      checks++;
      fails++;
      $display("FAIL R1/R8/R9 quiet window: actual oe=1 expected oe=0 at %0t", $time);
    end
  end

  task automatic hc(input int n);
    repeat (n) @(posedge clk);
  endtask

  task automatic bus_start();
    quiet = 1'b0;
    hc(H/2); m_sda = 1'b1; hc(H/2); m_scl = 1'b1; hc(H);
    m_sda = 1'b0; hc(H); m_scl = 1'b0;
  endtask

  task automatic bus_stop();
    hc(H/2); m_sda = 1'b0; hc(H/2); m_scl = 1'b1; hc(H);
    m_sda = 1'b1; hc(H);
    hc(4); quiet = 1'b1;
  endtask

  task automatic clock_bit(input logic b, output logic s);
    logic s2;
    hc(H/2); m_sda = b; hc(H/2); m_scl = 1'b1;
    hc(H/2); @(negedge clk); s = sda_bus;
    hc(H/2 - 1); @(negedge clk); s2 = sda_bus;
    check("R10 bit stable while clock high", int'(s2), int'(s));
    @(posedge clk); m_scl = 1'b0;
  endtask

  task automatic send_byte(input logic [7:0] b, output logic ack);
    logic s;
    for (int i = 7; i >= 0; i--) clock_bit(b[i], s);
    clock_bit(1'b1, s);
    ack = ~s;
  endtask

  task automatic recv_byte(input logic give_ack, output logic [7:0] b);
    logic s;
    for (int i = 7; i >= 0; i--) begin
      clock_bit(1'b1, s);
      b[i] = s;
    end
    clock_bit(~give_ack, s);
  endtask

  task automatic set_addr(input logic [15:0] a);
    logic ack;
    send_byte({7'h54, 1'b0}, ack); check("R5 ack dev addr write", int'(ack), 1);
    send_byte(a[15:8], ack);       check("R5 ack addr high", int'(ack), 1);
    send_byte(a[7:0], ack);        check("R5 ack addr low", int'(ack), 1);
  endtask

  task automatic wr_txn(input logic [15:0] a, input int n, input logic [31:0] d);
    logic ack;
    int   idx;
    idx = int'(a) % NREG;
    bus_start();
    set_addr(a);
    for (int i = 0; i < n; i++) begin
      send_byte(d[8*(i%4) +: 8], ack);
      check("R5 ack write data", int'(ack), 1);
      if (i % 4 == 1) mdl[idx][15:0]  = d[15:0];
      if (i % 4 == 3) mdl[idx][31:16] = d[31:16];
    end
    bus_stop();
  endtask

  task automatic rd_txn(input logic [15:0] a, input int n, input string req);
    logic ack;
    logic [7:0] b;
    int idx;
    idx = int'(a) % NREG;
    bus_start();
    set_addr(a);
    bus_start();
    send_byte({7'h54, 1'b1}, ack); check("R5 ack dev addr read", int'(ack), 1);
    for (int i = 0; i < n; i++) begin
      recv_byte(i < n - 1, b);
      check(req, int'(b), int'(mdl[idx][8*(i%4) +: 8]));
    end
    bus_stop();
  endtask

  initial begin
    int cyc = 0;
    while (cyc < WATCHDOG) begin
      @(posedge clk);
      cyc++;
    end
    fails++;
    $display("FAIL watchdog expired: actual=running expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    logic ack, s;
    logic [7:0] b;
    for (int i = 0; i < NREG; i++) mdl[i] = '0;
    hc(5);
    @(negedge clk);
    check("R9 released during reset", int'(sda_oe), 0);
    rst_n = 1'b1;
    hc(10);
    rd_txn(16'h0000, 4, "R9 register zero after reset");

    // full word, byte order and bit order
    wr_txn(16'h0003, 4, 32'hA1B2C3D4);
    rd_txn(16'h0003, 4, "R4 read bytes LSB first");
    rd_txn(16'h0003, 6, "R7 read byte position wraps");

    // high address byte sent first; swapped order would hit index 0
    wr_txn(16'h0006, 4, 32'h11223344);
    rd_txn(16'h0006, 4, "R3 address high byte first");
    rd_txn(16'h0000, 1, "R3 other register untouched");
    wr_txn(16'h1205, 4, 32'h5A5AF00F);
    rd_txn(16'h0005, 4, "R3 address aliases modulo count");

    // partial writes
    wr_txn(16'h0003, 2, 32'h0000BEEF);
    rd_txn(16'h0003, 4, "R6 16-bit write keeps upper half");
    wr_txn(16'h0003, 1, 32'h00000077);
    rd_txn(16'h0003, 4, "R6 single byte commits nothing");
    wr_txn(16'h0003, 3, 32'h00990102);
    rd_txn(16'h0003, 4, "R6 three bytes commit low half only");

    // foreign device address
    bus_start();
    quiet = 1'b1;
    send_byte({7'h50, 1'b0}, ack); check("R1 foreign address not acked", int'(ack), 0);
    send_byte(8'h00, ack);         check("R1 silent after foreign address", int'(ack), 0);
    send_byte(8'h03, ack);         check("R1 silent after foreign address", int'(ack), 0);
    send_byte(8'hFF, ack);         check("R1 silent after foreign address", int'(ack), 0);
    send_byte(8'hFF, ack);         check("R1 silent after foreign address", int'(ack), 0);
    bus_stop();
    rd_txn(16'h0003, 4, "R1 foreign write changed nothing");

    // master no-acknowledge ends the read
    bus_start();
    set_addr(16'h0006);
    bus_start();
    send_byte({7'h54, 1'b1}, ack); check("R5 ack dev addr read", int'(ack), 1);
    recv_byte(1'b1, b); check("R8 first byte after ack", int'(b), int'(mdl[6][7:0]));
    recv_byte(1'b0, b); check("R8 byte before nack", int'(b), int'(mdl[6][15:8]));
    hc(4);
    quiet = 1'b1;
    for (int i = 0; i < 9; i++) begin
      clock_bit(1'b1, s);
      check("R8 released after nack", int'(s), 1);
    end
    bus_stop();

    // START in the middle of a data byte aborts it
    bus_start();
    set_addr(16'h0002);
    send_byte(8'h12, ack); check("R5 ack write data", int'(ack), 1);
    clock_bit(1'b0, s);
    clock_bit(1'b1, s);
    bus_start();
    send_byte({7'h54, 1'b1}, ack); check("R2 START restarts address byte", int'(ack), 1);
    recv_byte(1'b0, b); check("R2 aborted write left register", int'(b), int'(mdl[2][7:0]));
    bus_stop();
    rd_txn(16'h0002, 4, "R2 aborted write committed nothing");

    // STOP in the middle of a write byte
    bus_start();
    set_addr(16'h0004);
    send_byte(8'h34, ack);
    clock_bit(1'b1, s);
    bus_stop();
    rd_txn(16'h0004, 4, "R2 STOP aborts write");

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule